// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a compact 32-bit processor core that completes one instruction every clock cycle. It runs a small load/store instruction set in which every instruction is one 32-bit word. The core holds a 32-entry general register file, a combinational arithmetic unit, a program-counter sequencer, and two word-wide arrays: one for instructions and one for data. In each cycle the current program counter selects an instruction word. The core decodes it, computes the result, reads or writes the data array, and commits the register result and the new program counter at the next rising edge.

Both arrays are filled before the program runs through a narrow preload port, which writes one word per cycle. While the program runs, the core reports what it is doing on dedicated outputs: the current program counter, the instruction word, the register write-back strobe with its index and value, and the data-store strobe with its address and value. A surrounding test harness or trace monitor can follow execution from these outputs alone.

Top module: `sc_proc`

## Requirements
- R1: Driving `rst_n` low immediately forces the program counter to 0, without waiting for a clock edge. After `rst_n` is released, the first instruction fetched is the word at byte address 0.
- R2: Register-to-register operations use opcode 000000, and the funct field [5:0] selects the operation. The codes are 100000 add, 100010 subtract, 100100 bitwise and, 100101 bitwise or, and 101010 set-on-less-than. Set-on-less-than writes 1 when rs is less than rt as signed numbers, and 0 otherwise. The result goes to rd, bits [15:11].
- R3: With opcode 000000, funct 000000 shifts rt left and funct 000010 shifts rt right, both logically. The shift distance comes from the shamt field, bits [10:6], and the result goes to rd.
- R4: Opcode 001000 adds the sign-extended 16-bit immediate to rs. Opcode 001101 ors rs with the zero-extended immediate. Opcode 001111 places the immediate in the upper half and zeroes the lower half. Each of these writes rt, bits [20:16].
- R5: Opcode 100011 loads a word and opcode 101011 stores a word. For both, the byte address is rs plus the sign-extended immediate, and the data array is indexed by address bits [31:2]. A store raises the store strobe with that address and the value of rt, and writes no register.
- R6: Register 0 always reads as zero. An instruction whose destination is register 0 raises no write-back strobe.
- R7: A branch is taken when rs and rt are equal under opcode 000100, or unequal under opcode 000101. A taken branch sets the program counter to the branch's own address plus the sign-extended immediate shifted left by two. A branch that is not taken advances the program counter by 4.
- R8: Opcode 000010 jumps to a target built from the upper four bits of PC+4, then the 26-bit field [25:0], then two zero bits. Opcode 000011 jumps to the same target and also writes PC+4 into register 31.
- R9: Opcode 000000 with funct 001000 loads the program counter from rs and writes no register.
- R10: An unknown opcode, or an unknown funct under opcode 000000, writes nothing and advances the program counter by 4.
- R11: The write-back and store outputs describe the instruction at the current program counter in the same cycle. The register, data-array and program-counter updates all take effect at the next rising edge.
- R12: While `ld_we_i` is high, each rising edge writes `ld_data_i` into word `ld_addr_i` of the array that `ld_dmem_i` selects: 1 selects the data array, 0 selects the instruction array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Preload write enable |
| ld_dmem_i | input | 1 | Preload target: 1 = data array, 0 = instruction array |
| ld_addr_i | input | 6 | Preload word index |
| ld_data_i | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current program counter |
| rf_we_o | output | 1 | Register write-back strobe |
| rf_waddr_o | output | 5 | Register written back |
| rf_wdata_o | output | 32 | Value written back |
| dm_we_o | output | 1 | Data store strobe |
| dm_addr_o | output | 32 | Byte address of the load or store |
| dm_wdata_o | output | 32 | Store data |

## Verification
The trace outputs are combinational from the program counter, so they are valid in the same cycle that the program counter presents an instruction. The effect of that instruction appears one rising edge later, either as the next program counter value or as a register or data word read by a later instruction. The bench therefore samples one nanosecond after each falling edge. At that point it compares the trace of the current instruction against a per-step table, and it checks each prior update only through the next entry's program counter or operand values. Reset is checked between edges, so the asynchronous clear of the program counter is observed before any clock arrives.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RAW    = $clog2(NREG);
  localparam int LINK_R = NREG - 1;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
  } alu_op_e;

  typedef enum logic [2:0] {
    PC_SEQ, PC_BEQ, PC_BNE, PC_JMP, PC_JR
  } pc_sel_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rt;
    logic    link;
    logic    alu_imm;
    logic    imm_zext;
    logic    mem_rd;
    logic    mem_wr;
    alu_op_e alu_op;
    pc_sel_e pc_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    rf_we: 1'b0, dst_rt: 1'b0, link: 1'b0, alu_imm: 1'b0, imm_zext: 1'b0,
    mem_rd: 1'b0, mem_wr: 1'b0, alu_op: ALU_ADD, pc_sel: PC_SEQ
  };

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output ctrl_t           ctrl_o
);

  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr_i[31:26];
  assign funct  = instr_i[5:0];

  always_comb begin
    ctrl_o = CTRL_NOP;
    unique case (opcode)
      OP_RTYPE: begin
        unique case (funct)
          FN_ADD: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
          FN_AND: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
          FN_OR:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
          FN_SLT: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SLT; end
          FN_SLL: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SLL; end
          FN_SRL: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SRL; end
          FN_JR:  ctrl_o.pc_sel = PC_JR;
          default: ctrl_o = CTRL_NOP;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.alu_imm = 1'b1;
        ctrl_o.alu_op = ALU_ADD;
      end
      OP_ORI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.alu_imm = 1'b1;
        ctrl_o.imm_zext = 1'b1; ctrl_o.alu_op = ALU_OR;
      end
      OP_LUI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.alu_imm = 1'b1;
        ctrl_o.alu_op = ALU_LUI;
      end
      OP_LW: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.alu_imm = 1'b1;
        ctrl_o.mem_rd = 1'b1; ctrl_o.alu_op = ALU_ADD;
      end
      OP_SW: begin
        ctrl_o.alu_imm = 1'b1; ctrl_o.mem_wr = 1'b1; ctrl_o.alu_op = ALU_ADD;
      end
      OP_BEQ: ctrl_o.pc_sel = PC_BEQ;
      OP_BNE: ctrl_o.pc_sel = PC_BNE;
      OP_J:   ctrl_o.pc_sel = PC_JMP;
      OP_JAL: begin
        ctrl_o.pc_sel = PC_JMP; ctrl_o.rf_we = 1'b1; ctrl_o.link = 1'b1;
      end
      default: ctrl_o = CTRL_NOP;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  input  alu_op_e              op_i,
  output logic [W-1:0]         y_o
);

  localparam int HALF = W / 2;

  logic lt_signed;
  assign lt_signed = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, lt_signed};
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      ALU_LUI: y_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int N   = NREG,
  parameter int NRD = 2,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [W-1:0]  rdata_o [NRD]
);

  logic [W-1:0] regs [N];
  logic         wr_en;

  assign wr_en = we_i && (waddr_i != '0);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs[raddr_i[p]];
  end

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] rs_val_i,
  input  logic         eq_i,
  input  pc_sel_e      sel_i,
  output logic [W-1:0] pc_plus4_o,
  output logic [W-1:0] pc_next_o
);

  localparam int IMMW = 16;
  localparam int JW   = 26;

  logic [W-1:0] br_off;
  logic [W-1:0] br_tgt;
  logic [W-1:0] j_tgt;

  assign pc_plus4_o = pc_i + W'(4);
  assign br_off     = {{(W-IMMW-2){instr_i[IMMW-1]}}, instr_i[IMMW-1:0], 2'b00};
  assign br_tgt     = pc_i + br_off;
  assign j_tgt      = {pc_plus4_o[W-1:JW+2], instr_i[JW-1:0], 2'b00};

  always_comb begin
    unique case (sel_i)
      PC_BEQ:  pc_next_o = eq_i  ? br_tgt : pc_plus4_o;
      PC_BNE:  pc_next_o = !eq_i ? br_tgt : pc_plus4_o;
      PC_JMP:  pc_next_o = j_tgt;
      PC_JR:   pc_next_o = rs_val_i;
      default: pc_next_o = pc_plus4_o;
    endcase
  end

endmodule

// File: rtl/sc_proc.sv
module sc_proc
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW   = $clog2(IMEM_WORDS),
  localparam int DAW   = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [XLEN-1:0]  ld_data_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  instr_o,
  output logic             rf_we_o,
  output logic [RAW-1:0]   rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             dm_we_o,
  output logic [XLEN-1:0]  dm_addr_o,
  output logic [XLEN-1:0]  dm_wdata_o
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;

  logic [RAW-1:0]  rd_addr [2];
  logic [XLEN-1:0] rd_data [2];
  logic [XLEN-1:0] rs_val, rt_val;

  logic [XLEN-1:0] imm_ext, alu_b, alu_y, ld_word;
  logic [RAW-1:0]  wb_addr;
  logic [XLEN-1:0] wb_data;
  logic            wb_en;
  logic            imem_ld_en, dmem_ld_en;

  // fetch
  assign instr = imem[pc_q[IAW+1:2]];

  sc_decode u_dec (
    .instr_i (instr),
    .ctrl_o  (ctrl)
  );

  // operand read
  assign rd_addr[0] = instr[25:21];
  assign rd_addr[1] = instr[20:16];
  assign rs_val     = rd_data[0];
  assign rt_val     = rd_data[1];

  // execute
  assign imm_ext = ctrl.imm_zext ? {16'h0, instr[15:0]}
                                 : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.alu_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i     (rs_val),
    .b_i     (alu_b),
    .shamt_i (instr[10:6]),
    .op_i    (ctrl.alu_op),
    .y_o     (alu_y)
  );

  sc_nextpc #(.W(XLEN)) u_npc (
    .pc_i       (pc_q),
    .instr_i    (instr),
    .rs_val_i   (rs_val),
    .eq_i       (rs_val == rt_val),
    .sel_i      (ctrl.pc_sel),
    .pc_plus4_o (pc_plus4),
    .pc_next_o  (pc_d)
  );

  // memory read
  assign ld_word = dmem[alu_y[DAW+1:2]];

  // write-back selection
  always_comb begin
    if (ctrl.link) begin
      wb_addr = RAW'(LINK_R);
    end else if (ctrl.dst_rt) begin
      wb_addr = instr[20:16];
    end else begin
      wb_addr = instr[15:11];
    end
  end

  always_comb begin
    if (ctrl.link) begin
      wb_data = pc_plus4;
    end else if (ctrl.mem_rd) begin
      wb_data = ld_word;
    end else begin
      wb_data = alu_y;
    end
  end

  assign wb_en = ctrl.rf_we && (wb_addr != '0);

  sc_regfile #(.W(XLEN), .N(NREG), .NRD(2)) u_rf (
    .clk     (clk),
    .we_i    (wb_en),
    .waddr_i (wb_addr),
    .wdata_i (wb_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  // program counter register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  // arrays: store has priority over preload on the data side
  assign imem_ld_en = ld_we_i && !ld_dmem_i;
  assign dmem_ld_en = ld_we_i &&  ld_dmem_i;

  always_ff @(posedge clk) begin
    if (imem_ld_en) begin
      imem[ld_addr_i[IAW-1:0]] <= ld_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.mem_wr) begin
      dmem[alu_y[DAW+1:2]] <= rt_val;
    end else if (dmem_ld_en) begin
      dmem[ld_addr_i[DAW-1:0]] <= ld_data_i;
    end
  end

  // trace outputs
  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = wb_en;
  assign rf_waddr_o = wb_addr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctrl.mem_wr;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

endmodule

// File: rtl/sc_proc_chk.sv
module sc_proc_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] instr_o,
  input logic            rf_we_o,
  input logic [RAW-1:0]  rf_waddr_o,
  input logic [XLEN-1:0] rf_wdata_o,
  input logic            dm_we_o
);

  logic [5:0]      op;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;

  assign op     = instr_o[31:26];
  assign seq_pc = pc_o + 32'd4;
  assign br_pc  = pc_o + {{14{instr_o[15]}}, instr_o[15:0], 2'b00};
  assign jmp_pc = {seq_pc[31:28], instr_o[25:0], 2'b00};

  assert_pc_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  assert_imm_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADDI || op == OP_ORI || op == OP_LUI || op == OP_LW || op == OP_SW)
    |=> pc_o == $past(seq_pc));

  assert_branch_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEQ || op == OP_BNE)
    |=> (pc_o == $past(seq_pc)) || (pc_o == $past(br_pc)));

  assert_jump_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_J || op == OP_JAL) |=> pc_o == $past(jmp_pc));

  assert_link_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JAL) |-> (rf_we_o && rf_waddr_o == 5'd31 && rf_wdata_o == seq_pc));

  assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SW) |-> (dm_we_o && !rf_we_o));

  assert_upper_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LUI && rf_we_o) |-> rf_wdata_o[15:0] == 16'h0000);

  assert_zero_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADDI && instr_o[20:16] == 5'd0) |-> !rf_we_o);

endmodule

bind sc_proc sc_proc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_o       (pc_o),
  .instr_o    (instr_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .rf_wdata_o (rf_wdata_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/sc_proc_tb.sv
module sc_proc_tb;

  localparam int NSTEP = 30;
  localparam int NPROG = 64;

  // row: pc, rf_we, waddr, wdata, dm_we, dm_addr, dm_wdata
  localparam logic [134:0] EXP [NSTEP] = '{
    {32'h00, 1'b1, 5'd1,  32'h12340000, 1'b0, 32'h0,  32'h0},
    {32'h04, 1'b1, 5'd1,  32'h12345678, 1'b0, 32'h0,  32'h0},
    {32'h08, 1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'h0,  32'h0},
    {32'h0C, 1'b1, 5'd3,  32'h00000005, 1'b0, 32'h0,  32'h0},
    {32'h10, 1'b1, 5'd4,  32'h00000002, 1'b0, 32'h0,  32'h0},
    {32'h14, 1'b1, 5'd5,  32'hFFFFFFF8, 1'b0, 32'h0,  32'h0},
    {32'h18, 1'b1, 5'd6,  32'h00000005, 1'b0, 32'h0,  32'h0},
    {32'h1C, 1'b1, 5'd7,  32'h1234567D, 1'b0, 32'h0,  32'h0},
    {32'h20, 1'b1, 5'd8,  32'h00000001, 1'b0, 32'h0,  32'h0},
    {32'h24, 1'b1, 5'd9,  32'h00000000, 1'b0, 32'h0,  32'h0},
    {32'h28, 1'b1, 5'd10, 32'h00000050, 1'b0, 32'h0,  32'h0},
    {32'h2C, 1'b1, 5'd11, 32'h0000000F, 1'b0, 32'h0,  32'h0},
    {32'h30, 1'b0, 5'd0,  32'h0,        1'b1, 32'h10, 32'h12345678},
    {32'h34, 1'b1, 5'd12, 32'h12345678, 1'b0, 32'h0,  32'h0},
    {32'h38, 1'b1, 5'd13, 32'hCAFEF00D, 1'b0, 32'h0,  32'h0},
    {32'h3C, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h40, 1'b1, 5'd14, 32'h00000005, 1'b0, 32'h0,  32'h0},
    {32'h44, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h48, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h50, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h5C, 1'b1, 5'd31, 32'h00000060, 1'b0, 32'h0,  32'h0},
    {32'h70, 1'b1, 5'd17, 32'hFFFFFFFF, 1'b0, 32'h0,  32'h0},
    {32'h74, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h60, 1'b1, 5'd16, 32'h00000077, 1'b0, 32'h0,  32'h0},
    {32'h64, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h90, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h80, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h84, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h88, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
    {32'h88, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we, ld_dmem;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc, instr, rf_wdata, dm_addr, dm_wdata;
  logic        rf_we, dm_we;
  logic [4:0]  rf_waddr;

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;
  logic [31:0] prog [NPROG];

  always #2 clk = ~clk;

  sc_proc u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_we_i    (ld_we),
    .ld_dmem_i  (ld_dmem),
    .ld_addr_i  (ld_addr),
    .ld_data_i  (ld_data),
    .pc_o       (pc),
    .instr_o    (instr),
    .rf_we_o    (rf_we),
    .rf_waddr_o (rf_waddr),
    .rf_wdata_o (rf_wdata),
    .dm_we_o    (dm_we),
    .dm_addr_o  (dm_addr),
    .dm_wdata_o (dm_wdata)
  );

  function automatic logic [31:0] enc_r(input int rs, rt, rd, sh, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] a);
    return {op, a};
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0, 1, 2, 3, 21, 23: return "R4";
      4, 5, 6, 7, 8, 9:   return "R2";
      10, 11:             return "R3";
      12, 13, 14:         return "R5";
      15, 16:             return "R6";
      17, 18, 19, 25:     return "R7";
      20, 24:             return "R8";
      22:                 return "R9";
      26, 27:             return "R10";
      default:            return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic load_word(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_we   = 1'b1;
    ld_dmem = sel;
    ld_addr = 6'(idx);
    ld_data = d;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] filler;
    logic [134:0] row;
    filler  = enc_i(6'b001000, 0, 15, 16'h0001);
    rst_n   = 1'b0;
    ld_we   = 1'b0;
    ld_dmem = 1'b0;
    ld_addr = '0;
    ld_data = '0;

    for (int i = 0; i < NPROG; i++) prog[i] = filler;
    prog[0]  = enc_i(6'b001111, 0, 1, 16'h1234);
    prog[1]  = enc_i(6'b001101, 1, 1, 16'h5678);
    prog[2]  = enc_i(6'b001000, 0, 2, 16'hFFFD);
    prog[3]  = enc_i(6'b001000, 0, 3, 16'h0005);
    prog[4]  = enc_r(2, 3, 4, 0, 6'b100000);
    prog[5]  = enc_r(2, 3, 5, 0, 6'b100010);
    prog[6]  = enc_r(2, 3, 6, 0, 6'b100100);
    prog[7]  = enc_r(1, 3, 7, 0, 6'b100101);
    prog[8]  = enc_r(2, 3, 8, 0, 6'b101010);
    prog[9]  = enc_r(3, 2, 9, 0, 6'b101010);
    prog[10] = enc_r(0, 3, 10, 4, 6'b000000);
    prog[11] = enc_r(0, 2, 11, 28, 6'b000010);
    prog[12] = enc_i(6'b101011, 3, 1, 16'd11);
    prog[13] = enc_i(6'b100011, 0, 12, 16'd16);
    prog[14] = enc_i(6'b100011, 0, 13, 16'd4);
    prog[15] = enc_i(6'b001000, 0, 0, 16'd7);
    prog[16] = enc_r(0, 3, 14, 0, 6'b100000);
    prog[17] = enc_i(6'b000100, 3, 4, 16'd5);
    prog[18] = enc_i(6'b000101, 3, 4, 16'd2);
    prog[20] = enc_i(6'b000100, 6, 3, 16'd3);
    prog[23] = enc_j(6'b000011, 26'h1C);
    prog[24] = enc_i(6'b001000, 0, 16, 16'h0077);
    prog[25] = enc_j(6'b000010, 26'h24);
    prog[28] = enc_i(6'b001000, 0, 17, 16'hFFFF);
    prog[29] = enc_r(31, 0, 0, 0, 6'b001000);
    prog[32] = 32'hFC00_0000;
    prog[33] = enc_r(1, 2, 18, 0, 6'b111111);
    prog[34] = enc_i(6'b000100, 0, 0, 16'h0000);
    prog[36] = enc_i(6'b000100, 0, 0, 16'hFFFC);

    // R12: preload both arrays through the load port while reset is held
    for (int i = 0; i < NPROG; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 1, 32'hCAFEF00D);

    #1;
    check(pc == 32'h0, "R1", "pc in reset", pc, 32'h0);
    check(instr == prog[0], "R12", "preloaded word 0", instr, prog[0]);

    @(negedge clk);
    rst_n = 1'b1;

    // R11: one table row per cycle, sampled after the falling edge
    for (int s = 0; s < NSTEP; s++) begin
      #1;
      row = EXP[s];
      check(pc == row[134:103], req_of(s), "pc", pc, row[134:103]);
      check(rf_we == row[102], req_of(s), "rf_we", 32'(rf_we), 32'(row[102]));
      if (row[102]) begin
        check(rf_waddr == row[101:97], req_of(s), "rf_waddr", 32'(rf_waddr), 32'(row[101:97]));
        check(rf_wdata == row[96:65], req_of(s), "rf_wdata", rf_wdata, row[96:65]);
      end
      check(dm_we == row[64], req_of(s), "dm_we", 32'(dm_we), 32'(row[64]));
      if (row[64]) begin
        check(dm_addr == row[63:32], req_of(s), "dm_addr", dm_addr, row[63:32]);
        check(dm_wdata == row[31:0], req_of(s), "dm_wdata", dm_wdata, row[31:0]);
      end
      @(negedge clk);
    end

    // R1: asynchronous clear between edges
    #1;
    check(pc == 32'h88, "R7", "halt loop holds", pc, 32'h88);
    rst_n = 1'b0;
    #0.5;
    check(pc == 32'h0, "R1", "async clear", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(pc == 32'h0 && rf_we && rf_wadd_ok(rf_waddr), "R11", "restart at 0",
          pc, 32'h0);
    check(instr == prog[0], "R12", "word 0 after restart", instr, prog[0]);
    @(negedge clk);
    #1;
    check(pc == 32'h4, "R11", "advance after restart", pc, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end

  function automatic bit rf_wadd_ok(input logic [4:0] a);
    return a == 5'd1;
  endfunction

endmodule